// File: doc/BRIEF.md
# Leaky Integrate-and-Fire Neuron Layer Pipeline

This block computes one timestep of a layer of spiking neurons. A timestep opens with a start pulse that empties every neuron's partial-sum register. A stream of input beats follows. Each beat carries one presynaptic spike bit and a row of signed weights, one weight per neuron. A beat whose spike bit is set adds its weight row into all partial sums at once. The sums stay in place in local registers while the stream passes. The beat flagged as last closes the accumulation.

The layer then walks its neurons one per cycle through two further stages. The dynamics stage leaks the membrane potential halfway toward the partial sum, using an arithmetic right shift instead of a multiplier. It fires when the threshold is reached, and a firing neuron's potential is reset to zero. The trace stage works on the same neuron one cycle later. It decays that neuron's spike trace by a programmable power-of-two fraction and adds an increment if the neuron fired. While the trace stage handles neuron i, the dynamics stage already handles neuron i+1. A one-cycle done pulse marks the end of the timestep.

Membrane potentials are 16-bit signed fixed point with 8 fractional bits, so the value 256 stands for 1.0. Traces are unsigned.

Top module: `lif_layer`

## Requirements
- R1: A start pulse accepted in the idle or accumulate phase sets all partial sums to 0 on the next edge and leaves the layer in the accumulate phase. A start during accumulation discards the sums gathered so far.
- R2: In the accumulate phase, a beat with in_valid=1 and in_spike=1 adds the signed weight at in_weights[i*16 +: 16] to partial sum i for every neuron i. The sum saturates at the limits of its 21-bit signed range. A beat with in_spike=0 adds nothing. Beats outside the accumulate phase have no effect.
- R3: A beat with in_valid=1 and in_last=1 ends accumulation, and its own spike still counts. Neurons 0 to N-1 then pass the dynamics stage one per cycle and the trace stage one cycle later. With the in_last beat taken at edge E0, the done pulse is visible after edge E(N+1).
- R4: The dynamics stage forms a candidate potential: the old potential V plus (partial sum − V) shifted right by one, arithmetically. The candidate is clamped to the 16-bit signed range [-32768, 32767].
- R5: If the candidate is greater than or equal to the signed threshold cfg_threshold, the neuron fires, spike_vec[i] becomes 1 and V becomes 0. Otherwise spike_vec[i] becomes 0 and V takes the candidate. Bit i of spike_vec changes only in neuron i's dynamics cycle.
- R6: The trace stage sets trace i to trace − (trace >> cfg_decay_k), plus cfg_trace_inc if neuron i fired in this timestep. The result saturates at 65535 (all ones). No trace changes outside its own trace cycle.
- R7: done is high for exactly one cycle, after the last neuron's trace has been written. start is ignored from the in_last edge until that done pulse.
- R8: After reset, all potentials, partial sums, traces, spike_vec and done are 0, and the layer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Opens a timestep and clears partial sums |
| in_valid | input | 1 | Input beat present |
| in_spike | input | 1 | Presynaptic spike bit of the beat |
| in_last | input | 1 | Beat is the final one of the timestep |
| in_weights | input | N*16 | Signed weight row, neuron i at bits i*16 +: 16 |
| cfg_threshold | input | 16 | Signed firing threshold |
| cfg_decay_k | input | 4 | Trace decay shift k (lambda = 1 − 2^-k) |
| cfg_trace_inc | input | 16 | Trace increment on a spike |
| spike_vec | output | N | Output spike bit per neuron |
| trace_flat | output | N*16 | Trace of neuron i at bits i*16 +: 16 |
| done | output | 1 | One-cycle pulse at the end of the timestep |

## Verification
The bound checker watches several rules on every cycle. An accepted start must zero the partial sums. The sums must stay frozen outside accumulation. A neuron that has just fired must hold a potential of zero. Traces must stay untouched in any cycle without a trace-stage entry. done must be a single pulse that follows the drain cycle. The arithmetic is left to the bench scenarios, which compare spikes, traces and done against a behavioural model on every cycle: the halving leak, both saturation limits, threshold equality, k=0 and k=15 decay, a restart mid-accumulation, and garbage inputs during the dynamics walk.

// File: rtl/lif_pkg.sv
package lif_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_ACCUM = 2'd1,
        PH_DYN   = 2'd2,
        PH_DRAIN = 2'd3
    } phase_e;
endpackage

// File: rtl/lif_psum_bank.sv
module lif_psum_bank #(
    parameter int N    = 8,
    parameter int W_W  = 16,
    parameter int PS_W = 21
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              add_en,
    input  logic [N*W_W-1:0]  weights,
    output logic [N*PS_W-1:0] psum_flat
);
    localparam logic signed [PS_W:0] PS_HI = (PS_W+1)'((64'sd1 <<< (PS_W-1)) - 1);
    localparam logic signed [PS_W:0] PS_LO = -PS_HI - 1;

    logic signed [PS_W-1:0] acc_q [N];
    logic signed [PS_W-1:0] acc_d [N];

    for (genvar i = 0; i < N; i++) begin : g_acc
        logic signed [W_W-1:0] w_i;
        logic signed [PS_W:0]  wide;
        assign w_i = weights[i*W_W +: W_W];

        always_comb begin
            wide     = $signed({acc_q[i][PS_W-1], acc_q[i]})
                     + $signed({{(PS_W+1-W_W){w_i[W_W-1]}}, w_i});
            acc_d[i] = acc_q[i];
            if (clear) begin
                acc_d[i] = '0;
            end else if (add_en) begin
                if (wide > PS_HI)      acc_d[i] = PS_HI[PS_W-1:0];
                else if (wide < PS_LO) acc_d[i] = PS_LO[PS_W-1:0];
                else                   acc_d[i] = wide[PS_W-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) acc_q[i] <= '0;
            else        acc_q[i] <= acc_d[i];
        end

        assign psum_flat[i*PS_W +: PS_W] = acc_q[i];
    end
endmodule

// File: rtl/lif_dyn_unit.sv
module lif_dyn_unit #(
    parameter int V_W  = 16,
    parameter int PS_W = 21
) (
    input  logic signed [PS_W-1:0] psum,
    input  logic signed [V_W-1:0]  vmem,
    input  logic signed [V_W-1:0]  thr,
    output logic signed [V_W-1:0]  v_next,
    output logic                   fire
);
    localparam int D_W = PS_W + 2;
    localparam logic signed [D_W-1:0] V_HI = D_W'((64'sd1 <<< (V_W-1)) - 1);
    localparam logic signed [D_W-1:0] V_LO = -V_HI - 1;

    logic signed [D_W-1:0] v_ext, diff, half, cand;
    logic signed [V_W-1:0] v_sat;

    always_comb begin
        v_ext = $signed({{(D_W-V_W){vmem[V_W-1]}}, vmem});
        diff  = $signed({{(D_W-PS_W){psum[PS_W-1]}}, psum}) - v_ext;
        half  = diff >>> 1;
        cand  = v_ext + half;
        if (cand > V_HI)      v_sat = V_HI[V_W-1:0];
        else if (cand < V_LO) v_sat = V_LO[V_W-1:0];
        else                  v_sat = cand[V_W-1:0];
        fire   = (v_sat >= thr);
        v_next = fire ? '0 : v_sat;
    end
endmodule

// File: rtl/lif_trace_unit.sv
module lif_trace_unit #(
    parameter int TR_W = 16,
    parameter int K_W  = 4
) (
    input  logic [TR_W-1:0] trace,
    input  logic [K_W-1:0]  k,
    input  logic [TR_W-1:0] inc,
    input  logic            spike,
    output logic [TR_W-1:0] trace_next
);
    logic [TR_W-1:0] decayed;
    logic [TR_W:0]   total;

    always_comb begin
        decayed    = trace - (trace >> k);
        total      = {1'b0, decayed} + (spike ? {1'b0, inc} : '0);
        trace_next = total[TR_W] ? '1 : total[TR_W-1:0];
    end
endmodule

// File: rtl/lif_layer.sv
module lif_layer #(
    parameter int N         = 8,
    parameter int W_W       = 16,
    parameter int V_W       = 16,
    parameter int TR_W      = 16,
    parameter int MAX_FANIN = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                in_valid,
    input  logic                in_spike,
    input  logic                in_last,
    input  logic [N*W_W-1:0]    in_weights,
    input  logic [V_W-1:0]      cfg_threshold,
    input  logic [$clog2(TR_W)-1:0] cfg_decay_k,
    input  logic [TR_W-1:0]     cfg_trace_inc,
    output logic [N-1:0]        spike_vec,
    output logic [N*TR_W-1:0]   trace_flat,
    output logic                done
);
    import lif_pkg::*;

    localparam int PS_W  = W_W + $clog2(MAX_FANIN) + 1;
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1;
    localparam int K_W   = $clog2(TR_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

    typedef struct packed {
        phase_e           phase;
        logic [IDX_W-1:0] idx;
        logic             pv;
        logic [IDX_W-1:0] pidx;
        logic             pspk;
        logic             done;
        logic [N-1:0]     spk;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic signed [V_W-1:0] vmem_d [N];
    logic signed [V_W-1:0] vmem_q [N];
    logic [TR_W-1:0]       trace_d [N];
    logic [TR_W-1:0]       trace_q [N];

    logic                  clear, add_en;
    logic [N*PS_W-1:0]     psum_flat;
    logic signed [PS_W-1:0] psum_sel;
    logic signed [V_W-1:0]  v_sel, v_new;
    logic                   fire;
    logic [TR_W-1:0]        tr_sel, tr_new;

    lif_psum_bank #(.N(N), .W_W(W_W), .PS_W(PS_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .clear(clear), .add_en(add_en),
        .weights(in_weights), .psum_flat(psum_flat)
    );

    assign psum_sel = psum_flat[ctl_q.idx*PS_W +: PS_W];
    assign v_sel    = vmem_q[ctl_q.idx];

    lif_dyn_unit #(.V_W(V_W), .PS_W(PS_W)) u_dyn (
        .psum(psum_sel), .vmem(v_sel), .thr(cfg_threshold),
        .v_next(v_new), .fire(fire)
    );

    assign tr_sel = trace_q[ctl_q.pidx];

    lif_trace_unit #(.TR_W(TR_W), .K_W(K_W)) u_trace (
        .trace(tr_sel), .k(cfg_decay_k), .inc(cfg_trace_inc),
        .spike(ctl_q.pspk), .trace_next(tr_new)
    );

    always_comb begin
        ctl_d      = ctl_q;
        vmem_d     = vmem_q;
        trace_d    = trace_q;
        ctl_d.pv   = 1'b0;
        ctl_d.done = 1'b0;
        clear      = 1'b0;
        add_en     = 1'b0;

        // stage 3: trace update for the neuron handled one cycle earlier
        if (ctl_q.pv) begin
            trace_d[ctl_q.pidx] = tr_new;
            ctl_d.done          = (ctl_q.pidx == LAST_IDX);
        end

        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start) begin
                    clear       = 1'b1;
                    ctl_d.phase = PH_ACCUM;
                end
            end
            PH_ACCUM: begin
                if (start) begin
                    clear = 1'b1;
                end else if (in_valid) begin
                    add_en = in_spike;
                    if (in_last) begin
                        ctl_d.phase = PH_DYN;
                        ctl_d.idx   = '0;
                    end
                end
            end
            PH_DYN: begin
                // stage 2: neuron dynamics for neuron idx
                vmem_d[ctl_q.idx]    = v_new;
                ctl_d.spk[ctl_q.idx] = fire;
                ctl_d.pv             = 1'b1;
                ctl_d.pidx           = ctl_q.idx;
                ctl_d.pspk           = fire;
                if (ctl_q.idx == LAST_IDX) ctl_d.phase = PH_DRAIN;
                else                       ctl_d.idx   = ctl_q.idx + 1'b1;
            end
            PH_DRAIN: begin
                ctl_d.phase = PH_IDLE;
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{phase: PH_IDLE, default: '0};
            for (int i = 0; i < N; i++) begin
                vmem_q[i]  <= '0;
                trace_q[i] <= '0;
            end
        end else begin
            ctl_q   <= ctl_d;
            vmem_q  <= vmem_d;
            trace_q <= trace_d;
        end
    end

    logic [N*V_W-1:0] vmem_flat;
    for (genvar i = 0; i < N; i++) begin : g_out
        assign trace_flat[i*TR_W +: TR_W] = trace_q[i];
        assign vmem_flat[i*V_W +: V_W]    = vmem_q[i];
    end

    assign spike_vec = ctl_q.spk;
    assign done      = ctl_q.done;

    phase_e           phase_w;
    logic             pv_w, pspk_w;
    logic [IDX_W-1:0] pidx_w;
    assign phase_w = ctl_q.phase;
    assign pv_w    = ctl_q.pv;
    assign pspk_w  = ctl_q.pspk;
    assign pidx_w  = ctl_q.pidx;
endmodule

// File: rtl/lif_layer_chk.sv
module lif_layer_chk #(
    parameter int N     = 8,
    parameter int V_W   = 16,
    parameter int TR_W  = 16,
    parameter int PS_W  = 21,
    parameter int IDX_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic                done,
    input lif_pkg::phase_e     phase,
    input logic                pv,
    input logic                pspk,
    input logic [IDX_W-1:0]    pidx,
    input logic [N*PS_W-1:0]   psum_flat,
    input logic [N*V_W-1:0]    vmem_flat,
    input logic [N*TR_W-1:0]   trace_flat
);
    import lif_pkg::*;

    a_r1_psum_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (start && (phase == PH_IDLE || phase == PH_ACCUM)) |=> (psum_flat == '0));

    a_r2_psum_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DYN || phase == PH_DRAIN) |=> $stable(psum_flat));

    a_r5_fire_resets_v: assert property (@(posedge clk) disable iff (!rst_n)
        (pv && pspk) |-> (vmem_flat[pidx*V_W +: V_W] == '0));

    a_r6_trace_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pv |=> $stable(trace_flat));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(phase) == PH_DRAIN));
endmodule

bind lif_layer lif_layer_chk #(
    .N(N), .V_W(V_W), .TR_W(TR_W), .PS_W(PS_W), .IDX_W(IDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .done(done),
    .phase(phase_w), .pv(pv_w), .pspk(pspk_w), .pidx(pidx_w),
    .psum_flat(psum_flat), .vmem_flat(vmem_flat), .trace_flat(trace_flat)
);

// File: tb/sim_lif_layer.sv
module sim_lif_layer;
    localparam int N    = 8;
    localparam int W_W  = 16;
    localparam int V_W  = 16;
    localparam int TR_W = 16;
    localparam int NIN  = 12;
    localparam int PS_MAX = (1 << 20) - 1;
    localparam int TR_MAX = (1 << TR_W) - 1;

    logic clk = 0;
    logic rst_n = 0;
    logic start = 0, in_valid = 0, in_spike = 0, in_last = 0;
    logic [N*W_W-1:0]  in_weights = '0;
    logic [V_W-1:0]    cfg_threshold = 16'd256;
    logic [3:0]        cfg_decay_k = 4'd2;
    logic [TR_W-1:0]   cfg_trace_inc = 16'd256;
    logic [N-1:0]      spike_vec;
    logic [N*TR_W-1:0] trace_flat;
    logic              done;

    int errors = 0, checks = 0, cycles = 0;

    always #4 clk = ~clk;

    lif_layer u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .in_spike(in_spike), .in_last(in_last), .in_weights(in_weights),
        .cfg_threshold(cfg_threshold), .cfg_decay_k(cfg_decay_k),
        .cfg_trace_inc(cfg_trace_inc), .spike_vec(spike_vec),
        .trace_flat(trace_flat), .done(done)
    );

    // behavioural reference: phase 0 idle, 1 accumulate, 2 walk, 3 drain
    int m_ps[N], m_v[N], m_tr[N];
    bit m_spk[N];
    int m_phase, m_idx, m_pidx;
    bit m_pend, m_pfire, m_done;

    function automatic int wgt(int i);
        return int'($signed(in_weights[i*W_W +: W_W]));
    endfunction

    always @(posedge clk) begin
        int t, c;
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                m_ps[i] = 0; m_v[i] = 0; m_tr[i] = 0; m_spk[i] = 0;
            end
            m_phase = 0; m_idx = 0; m_pidx = 0; m_pend = 0; m_pfire = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (m_pend) begin
                t = m_tr[m_pidx];
                t = t - (t >> cfg_decay_k);
                if (m_pfire) t = t + int'(cfg_trace_inc);
                if (t > TR_MAX) t = TR_MAX;
                m_tr[m_pidx] = t;
                if (m_pidx == N - 1) m_done = 1;
            end
            m_pend = 0;
            if (m_phase == 0) begin
                if (start) begin
                    for (int i = 0; i < N; i++) m_ps[i] = 0;
                    m_phase = 1;
                end
            end else if (m_phase == 1) begin
                if (start) begin
                    for (int i = 0; i < N; i++) m_ps[i] = 0;
                end else if (in_valid) begin
                    if (in_spike)
                        for (int i = 0; i < N; i++) begin
                            m_ps[i] = m_ps[i] + wgt(i);
                            if (m_ps[i] > PS_MAX) m_ps[i] = PS_MAX;
                            if (m_ps[i] < -PS_MAX - 1) m_ps[i] = -PS_MAX - 1;
                        end
                    if (in_last) begin m_phase = 2; m_idx = 0; end
                end
            end else if (m_phase == 2) begin
                c = m_v[m_idx] + ((m_ps[m_idx] - m_v[m_idx]) >>> 1);
                if (c > 32767) c = 32767;
                if (c < -32768) c = -32768;
                m_pfire = (c >= int'($signed(cfg_threshold)));
                m_v[m_idx] = m_pfire ? 0 : c;
                m_spk[m_idx] = m_pfire;
                m_pend = 1; m_pidx = m_idx;
                if (m_idx == N - 1) m_phase = 3; else m_idx = m_idx + 1;
            end else begin
                m_phase = 0;
            end
        end
    end

    // compare on every falling edge while out of reset
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++) begin
                checks++;
                if (spike_vec[i] !== m_spk[i]) begin
                    errors++;
                    $display("FAIL R4/R5 spike[%0d] got %0b exp %0b", i, spike_vec[i], m_spk[i]);
                end
                checks++;
                if (int'(trace_flat[i*TR_W +: TR_W]) != m_tr[i]) begin
                    errors++;
                    $display("FAIL R6 trace[%0d] got %0d exp %0d", i, trace_flat[i*TR_W +: TR_W], m_tr[i]);
                end
            end
            checks++;
            if (done !== m_done) begin
                errors++;
                $display("FAIL R7 done got %0b exp %0b", done, m_done);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0d exp %0d", tag, got, exp);
        end
    endtask

    task automatic set_row(input int lo, input int hi);
        for (int i = 0; i < N; i++)
            in_weights[i*W_W +: W_W] = W_W'(lo + int'($urandom_range(0, hi - lo)));
    endtask

    task automatic set_const(input int w);
        for (int i = 0; i < N; i++) in_weights[i*W_W +: W_W] = W_W'(w);
    endtask

    // run one timestep: nbeats beats, weights in [lo,hi], spike probability 1 in 2
    task automatic timestep(input int nbeats, input int lo, input int hi, input int mode);
        int cnt;
        @(negedge clk); start = 1;
        @(negedge clk); start = 0;
        for (int b = 0; b < nbeats; b++) begin
            in_valid = 1;
            in_spike = (mode == 1) ? 1'b1 : ((mode == 2) ? 1'b0 : 1'($urandom_range(0, 1)));
            in_last  = (b == nbeats - 1);
            if (lo == hi) set_const(lo); else set_row(lo, hi);
            @(negedge clk);
        end
        cnt = 0;
        while (!done && cnt < 40) begin
            cnt++;
            if (cnt <= N) begin
                // garbage during the walk must be ignored (R2, R7)
                in_valid = 1; in_spike = 1; in_last = 1; start = 1; set_const(30000);
            end else begin
                in_valid = 0; in_spike = 0; in_last = 0; start = 0;
            end
            @(negedge clk);
        end
        in_valid = 0; in_spike = 0; in_last = 0; start = 0;
        check(cnt == N + 1, "R3 done latency after in_last", cnt + 1, N + 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check(spike_vec == '0, "R8 reset spike_vec", int'(spike_vec), 0);
        check(trace_flat == '0, "R8 reset traces", 0, 0);
        check(done == 1'b0, "R8 reset done", int'(done), 0);

        // ordinary timesteps with mixed spikes
        for (int s = 0; s < 6; s++) timestep(NIN, -200, 500, 0);
        // no spikes at all: sums stay 0 (R2)
        timestep(NIN, 20000, 20000, 2);
        // restart during accumulation (R1)
        @(negedge clk); start = 1;
        @(negedge clk); start = 0; in_valid = 1; in_spike = 1; set_const(30000);
        @(negedge clk); in_valid = 0;
        timestep(3, 100, 100, 1);
        // positive saturation, threshold at the maximum: equality fires (R4, R5)
        cfg_threshold = 16'sd32767;
        timestep(NIN, 32767, 32767, 1);
        check(spike_vec == '1, "R4 saturated candidate fires at max threshold", int'(spike_vec), 255);
        // negative saturation
        cfg_threshold = 16'sd256;
        timestep(NIN, -32768, -32768, 1);
        timestep(NIN, -32768, -32768, 1);
        // trace saturation with slow decay (R6)
        cfg_decay_k = 4'd15; cfg_trace_inc = 16'hF000; cfg_threshold = -16'sd32768;
        timestep(2, 0, 0, 1);
        timestep(2, 0, 0, 1);
        check(trace_flat[TR_W-1:0] == 16'hFFFF, "R6 trace saturates", int'(trace_flat[TR_W-1:0]), 65535);
        // k = 0: trace reduces to increment or zero
        cfg_decay_k = 4'd0; cfg_trace_inc = 16'd77; cfg_threshold = 16'sd128;
        for (int s = 0; s < 4; s++) timestep(NIN, -100, 300, 0);
        cfg_decay_k = 4'd3;
        for (int s = 0; s < 4; s++) timestep(NIN, -300, 600, 0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule